// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a register mailbox between a host processor and an embedded management controller. The host places up to four 32-bit words of request data in a write buffer and then writes a command word. Writing the command word launches the request: the block marks itself busy and gives the controller a one-cycle doorbell pulse. The controller reads the command, the request words and two pointer registers over a small parallel port. It writes its answer words into a read buffer. It then raises a done strobe that carries an error flag, an error code and an initiator id.

The host polls the status register, or asks for a completion pulse by setting a bit in the command word. Host writes that arrive while a command is in flight are dropped. Each dropped write sets a sticky overrun flag that the controller can see.

Control is a four-state machine:
- IDLE: no command in flight.
- LAUNCH: one cycle, busy, doorbell high.
- BUSY: waiting for the controller.
- FINISH: one cycle, busy low, completion pulse when requested.

Its transitions:
- IDLE→LAUNCH on a command write.
- LAUNCH→FINISH on done, otherwise LAUNCH→BUSY.
- BUSY→FINISH on done.
- FINISH→LAUNCH on a command write, otherwise FINISH→IDLE.

Top module: `mbx_top`

## Requirements
- R1: After reset the status word reads 0, and the completion pulse, doorbell and overrun flag are all low.
- R2: A host write to offset 0x00 while not busy is accepted. The doorbell is high for exactly the one cycle after the write edge, and status bit 0 (busy) reads 1 from then until done.
- R3: On acceptance, command bits [15:12] are copied into status bits [7:4]. The whole command word becomes readable by the controller at port index 4.
- R4: A controller done strobe while busy clears busy on the next cycle. It latches the error flag into status bit 1, the initiator id into bits [15:8] and the error code into bits [23:16]. Status bit 1 reads 0 while busy.
- R5: The completion pulse is high for exactly the one cycle after the done edge, and only when bit 8 of the accepted command was 1.
- R6: Host writes to offset 0x00 or to 0x80..0x8F while busy change nothing, and set the overrun flag. The flag stays set until reset.
- R7: The write buffer at 0x80 + 4·i accepts a host write only when all four byte enables are set. The controller reads word i at port index i. A partial write while not busy is ignored and does not set overrun.
- R8: The controller writes read-buffer word i. A host word read at 0x90 + 4·i returns that word. A byte read returns byte address[1:0] of it in bits [7:0], with zeros above.
- R9: Host writes to 0x08 and 0x0C are always taken, and the controller reads them at port indices 5 and 6. Host reads of 0x00, 0x08, 0x0C and the write buffer return 0.
- R10: Host read data is registered. It is valid in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 8 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_be | input | 4 | Host byte enables |
| h_byte | input | 1 | Host read is a byte read |
| h_rdata | output | 32 | Host read data, registered |
| h_irq | output | 1 | Completion pulse to host |
| c_doorbell | output | 1 | Doorbell pulse to controller |
| c_raddr | input | 3 | Controller read index (0-3 buffer, 4 command, 5/6 pointers) |
| c_rdata | output | 32 | Controller read data |
| c_wr | input | 1 | Controller read-buffer write strobe |
| c_widx | input | 2 | Controller read-buffer word index |
| c_wdata | input | 32 | Controller read-buffer write data |
| c_done | input | 1 | Controller completion strobe |
| c_err | input | 1 | Failure flag with done |
| c_ecode | input | 8 | Error code with done |
| c_init | input | 8 | Initiator id with done |
| c_overrun | output | 1 | Sticky dropped-write flag |

## Verification
Doorbell, busy and the copied command id are due in the cycle after the command-write edge. Cleared busy, latched error fields and the completion pulse are due in the cycle after the done edge. Host read data is due one cycle after the read strobe, and controller-side reads are combinational. The bench drives every strobe on a falling edge for a single cycle and samples on the following falling edge. It also checks on the next falling edge that doorbell and completion have dropped again.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_BUSY   = 2'd2,
        ST_FINISH = 2'd3
    } mbx_state_e;

    // command word fields
    localparam int CMD_IOC_BIT = 8;
    localparam int CMD_CID_LO  = 12;
    // status word fields
    localparam int ST_BUSY_BIT = 0;
    localparam int ST_ERR_BIT  = 1;
    localparam int ST_CID_LO   = 4;
    localparam int ST_INIT_LO  = 8;
    localparam int ST_CODE_LO  = 16;
endpackage

// File: rtl/mbx_fsm.sv
module mbx_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_go,
    input  logic done,
    output logic busy,
    output logic doorbell,
    output logic finish,
    output logic accept
);
    mbx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_go) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = done ? ST_FINISH : ST_BUSY;
            ST_BUSY:   if (done) state_d = ST_FINISH;
            ST_FINISH: state_d = cmd_go ? ST_LAUNCH : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b0;
        doorbell = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LAUNCH: begin busy = 1'b1; doorbell = 1'b1; end
            ST_BUSY:   busy = 1'b1;
            ST_FINISH: finish = 1'b1;
            default:   ;
        endcase
        accept = cmd_go && !busy;
    end

    // R2
    doorbell_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell);
    // R4
    finish_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> (finish && !busy));
endmodule

// File: rtl/mbx_wordbuf.sv
module mbx_wordbuf #(
    parameter int DW = 32,
    parameter int NW = 4,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] word_q [NW];

    for (genvar g = 0; g < NW; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                          word_q[g] <= '0;
            else if (we && (widx == IW'(g)))     word_q[g] <= wdata;
        end
    end

    assign rdata = word_q[ridx];
endmodule

// File: rtl/mbx_hostrd.sv
module mbx_hostrd #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          sel_status,
    input  logic          sel_rbuf,
    input  logic          byte_mode,
    input  logic [1:0]    byte_sel,
    input  logic [DW-1:0] status_word,
    input  logic [DW-1:0] rbuf_word,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mux_d;
    logic [7:0]    byte_v;

    always_comb begin
        byte_v = rbuf_word[8*byte_sel +: 8];
        mux_d  = '0;
        if (sel_status)     mux_d = status_word;
        else if (sel_rbuf)  mux_d = byte_mode ? DW'(byte_v) : rbuf_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= mux_d;
    end

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/mbx_top.sv
module mbx_top
    import mbx_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter int NW        = 4,
    parameter int CMD_OFS   = 'h00,
    parameter int STAT_OFS  = 'h04,
    parameter int SPTR_OFS  = 'h08,
    parameter int DPTR_OFS  = 'h0C,
    parameter int WBUF_OFS  = 'h80,
    parameter int RBUF_OFS  = 'h90,
    localparam int IW       = (NW > 1) ? $clog2(NW) : 1,
    localparam int BW       = DW / 8,
    localparam int BUF_SPAN = NW * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    input  logic [BW-1:0] h_be,
    input  logic          h_byte,
    output logic [DW-1:0] h_rdata,
    output logic          h_irq,
    output logic          c_doorbell,
    input  logic [2:0]    c_raddr,
    output logic [DW-1:0] c_rdata,
    input  logic          c_wr,
    input  logic [IW-1:0] c_widx,
    input  logic [DW-1:0] c_wdata,
    input  logic          c_done,
    input  logic          c_err,
    input  logic [7:0]    c_ecode,
    input  logic [7:0]    c_init,
    output logic          c_overrun
);
    // address decode
    logic hit_cmd, hit_stat, hit_sptr, hit_dptr, hit_wbuf, hit_rbuf;
    logic [IW-1:0] word_idx;

    always_comb begin
        hit_cmd  = (int'(h_addr) == CMD_OFS);
        hit_stat = (int'(h_addr) == STAT_OFS);
        hit_sptr = (int'(h_addr) == SPTR_OFS);
        hit_dptr = (int'(h_addr) == DPTR_OFS);
        hit_wbuf = (int'(h_addr) >= WBUF_OFS) && (int'(h_addr) < WBUF_OFS + BUF_SPAN);
        hit_rbuf = (int'(h_addr) >= RBUF_OFS) && (int'(h_addr) < RBUF_OFS + BUF_SPAN);
        word_idx = h_addr[IW+1:2];
    end

    // sequencing
    logic busy, finish, accept, cmd_go, done_ok;

    assign cmd_go  = h_wr && hit_cmd;
    assign done_ok = c_done && busy;

    mbx_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_go   (cmd_go),
        .done     (done_ok),
        .busy     (busy),
        .doorbell (c_doorbell),
        .finish   (finish),
        .accept   (accept)
    );

    // command, pointers, completion fields
    logic [DW-1:0] cmd_q, sptr_q, dptr_q;
    logic          err_q, ovr_q;
    logic [7:0]    code_q, init_q;
    logic          wbuf_we, wbuf_drop;

    assign wbuf_we   = h_wr && hit_wbuf && (h_be == '1) && !busy;
    assign wbuf_drop = h_wr && hit_wbuf && busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            sptr_q <= '0;
            dptr_q <= '0;
            err_q  <= 1'b0;
            code_q <= '0;
            init_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (accept) begin
                cmd_q  <= h_wdata;
                err_q  <= 1'b0;
                code_q <= '0;
                init_q <= '0;
            end
            if (done_ok) begin
                err_q  <= c_err;
                code_q <= c_ecode;
                init_q <= c_init;
            end
            if (h_wr && hit_sptr) sptr_q <= h_wdata;
            if (h_wr && hit_dptr) dptr_q <= h_wdata;
            if ((cmd_go && busy) || wbuf_drop) ovr_q <= 1'b1;
        end
    end

    assign c_overrun = ovr_q;
    assign h_irq     = finish && cmd_q[CMD_IOC_BIT];

    logic [DW-1:0] status_word;
    always_comb begin
        status_word = '0;
        status_word[ST_BUSY_BIT]           = busy;
        status_word[ST_ERR_BIT]            = err_q && !busy;
        status_word[ST_CID_LO +: 4]        = cmd_q[CMD_CID_LO +: 4];
        status_word[ST_INIT_LO +: 8]       = init_q;
        status_word[ST_CODE_LO +: 8]       = code_q;
    end

    // buffers
    logic [DW-1:0] wbuf_rd, rbuf_rd;

    mbx_wordbuf #(.DW(DW), .NW(NW)) u_wbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wbuf_we),
        .widx  (word_idx),
        .wdata (h_wdata),
        .ridx  (c_raddr[IW-1:0]),
        .rdata (wbuf_rd)
    );

    mbx_wordbuf #(.DW(DW), .NW(NW)) u_rbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (c_wr),
        .widx  (c_widx),
        .wdata (c_wdata),
        .ridx  (word_idx),
        .rdata (rbuf_rd)
    );

    // controller read port
    always_comb begin
        unique case (c_raddr)
            3'd4:    c_rdata = cmd_q;
            3'd5:    c_rdata = sptr_q;
            3'd6:    c_rdata = dptr_q;
            3'd7:    c_rdata = '0;
            default: c_rdata = wbuf_rd;
        endcase
    end

    mbx_hostrd #(.DW(DW)) u_hrd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd          (h_rd),
        .sel_status  (hit_stat),
        .sel_rbuf    (hit_rbuf),
        .byte_mode   (h_byte),
        .byte_sel    (h_addr[1:0]),
        .status_word (status_word),
        .rbuf_word   (rbuf_rd),
        .rdata       (h_rdata)
    );

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_overrun |=> c_overrun);
    // R6
    busy_cmd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && h_wr && hit_cmd) |=> $stable(cmd_q));
    // R5
    irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_irq |-> $past(c_done));
    // R5
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_irq |=> !h_irq);
endmodule

// File: tb/sim_mbx_top.sv
module sim_mbx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 0, h_rd = 0, h_byte = 0;
    logic [7:0]  h_addr = 0;
    logic [31:0] h_wdata = 0;
    logic [3:0]  h_be = 0;
    logic [31:0] h_rdata;
    logic        h_irq, c_doorbell, c_overrun;
    logic [2:0]  c_raddr = 0;
    logic [31:0] c_rdata;
    logic        c_wr = 0, c_done = 0, c_err = 0;
    logic [1:0]  c_widx = 0;
    logic [31:0] c_wdata = 0;
    logic [7:0]  c_ecode = 0, c_init = 0;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [31:0] m_wbuf [4];
    logic [31:0] m_rbuf [4];
    logic        m_ovr;

    always #5 clk = ~clk;

    mbx_top u0 (.*);

    function automatic logic [31:0] exp_status(bit busy, bit err, logic [3:0] cid,
                                               logic [7:0] init, logic [7:0] code);
        return {8'h00, code, init, cid, 2'b00, err & ~busy, busy};
    endfunction

    function automatic logic [31:0] exp_byte(logic [31:0] w, logic [1:0] s);
        return {24'h0, w[8*s +: 8]};
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic hwr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk); h_wr = 1; h_addr = a; h_wdata = d; h_be = be;
        @(negedge clk); h_wr = 0; h_be = 0;
    endtask

    task automatic hrd(logic [7:0] a, bit byt, output logic [31:0] d);
        @(negedge clk); h_rd = 1; h_addr = a; h_byte = byt;
        @(negedge clk); h_rd = 0; h_byte = 0; d = h_rdata;
    endtask

    task automatic crd(logic [2:0] i, output logic [31:0] d);
        c_raddr = i; #1; d = c_rdata;
    endtask

    task automatic cwr(logic [1:0] i, logic [31:0] d);
        @(negedge clk); c_wr = 1; c_widx = i; c_wdata = d;
        @(negedge clk); c_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, cmd, sp, dp;
        logic [3:0]  cid;
        logic [7:0]  code, ini;
        bit          ioc, er;
        void'($urandom(32'h1234abcd));
        for (int i = 0; i < 4; i++) begin m_wbuf[i] = 0; m_rbuf[i] = 0; end
        m_ovr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        hrd(8'h04, 0, v); chk("R1 status", v, 32'h0);
        chk("R1 irq/doorbell/ovr", {h_irq, c_doorbell, c_overrun}, 3'b000);

        // R9 write-only locations read 0
        hwr(8'h08, 32'h1111_2222, 4'hF);
        hrd(8'h08, 0, v); chk("R9 sptr host read", v, 32'h0);
        hrd(8'h00, 0, v); chk("R9 cmd host read", v, 32'h0);

        // R7 partial write ignored, no overrun
        hwr(8'h80, 32'hDEAD_BEEF, 4'h3);
        crd(3'd0, v); chk("R7 partial ignored", v, 32'h0);
        chk("R7 no overrun", {31'b0, c_overrun}, 32'h0);

        for (int it = 0; it < 40; it++) begin
            for (int w = 0; w < 4; w++) begin
                m_wbuf[w] = $urandom;
                hwr(8'h80 + 8'(4*w), m_wbuf[w], 4'hF);
            end
            sp = $urandom; dp = $urandom;
            hwr(8'h08, sp, 4'hF); hwr(8'h0C, dp, 4'hF);
            for (int w = 0; w < 4; w++) begin
                crd(3'(w), v); chk("R7 wbuf word", v, m_wbuf[w]);
            end
            crd(3'd5, v); chk("R9 sptr", v, sp);
            crd(3'd6, v); chk("R9 dptr", v, dp);

            cid = 4'($urandom); ioc = 1'($urandom);
            cmd = {8'h00, 8'($urandom), cid, 3'b000, ioc, 8'($urandom)};
            hwr(8'h00, cmd, 4'hF);
            chk("R2 doorbell", {31'b0, c_doorbell}, 32'h1);
            @(negedge clk);
            chk("R2 doorbell drop", {31'b0, c_doorbell}, 32'h0);
            hrd(8'h04, 0, v); chk("R3 busy+cid", v, exp_status(1, 0, cid, 0, 0));
            crd(3'd4, v); chk("R3 cmd seen", v, cmd);

            if (it % 3 == 0) begin
                hwr(8'h00, cmd ^ 32'h0000_F000, 4'hF);
                hwr(8'h84, ~m_wbuf[1], 4'hF);
                m_ovr = 1;
                hrd(8'h04, 0, v); chk("R6 cid kept", v, exp_status(1, 0, cid, 0, 0));
                crd(3'd1, v); chk("R6 wbuf kept", v, m_wbuf[1]);
            end
            chk("R6 overrun", {31'b0, c_overrun}, {31'b0, m_ovr});

            for (int w = 0; w < 4; w++) begin
                m_rbuf[w] = $urandom; cwr(2'(w), m_rbuf[w]);
            end
            er = 1'($urandom); code = 8'($urandom); ini = 8'($urandom);
            @(negedge clk); c_done = 1; c_err = er; c_ecode = code; c_init = ini;
            @(negedge clk); c_done = 0; c_err = 0;
            chk("R5 irq", {31'b0, h_irq}, {31'b0, ioc});
            @(negedge clk);
            chk("R5 irq drop", {31'b0, h_irq}, 32'h0);
            hrd(8'h04, 0, v); chk("R4 status", v, exp_status(0, er, cid, ini, code));
            for (int w = 0; w < 4; w++) begin
                hrd(8'h90 + 8'(4*w), 0, v); chk("R8 word", v, m_rbuf[w]);
            end
            begin
                int w = it % 4;
                logic [1:0] s = 2'($urandom);
                hrd(8'h90 + 8'(4*w) + 8'(s), 1, v);
                chk("R8 byte", v, exp_byte(m_rbuf[w], s));
                // R10 data holds with no read strobe
                @(negedge clk); chk("R10 hold", h_rdata, exp_byte(m_rbuf[w], s));
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule